// File: doc/BRIEF.md
# Front-Light Pulse-Width Dimmer

This block drives the dimming line of a display front light with a pulse-width-modulated waveform. A slow 32 kHz real-time clock paces a counter. Software writes a period value and a duty value over a simple synchronous register port. While the counter sits below the duty value the line is driven high. For the rest of the period it is driven low. New period and duty values reach the counter only at a period boundary, so a write never produces a truncated or stretched pulse.

Two conditions hold the line at a fixed level and park the counter at zero: an external power-enable pin and a software enable bit. A polarity bit flips the final output. When the resync option is on, a rising edge on an external touch-panel sync line restarts the period at once. An active-low power-fault input clears every register of the block.

The block runs on one system clock. The real-time clock, the sync line and the power-enable pin are treated as asynchronous levels and pass through synchronizer chains. Each rising edge of the real-time clock then produces one single-cycle count step.

Top module: `flpwm_gen`

## Requirements
- R1: While `pwr_fault_n` is low, and after it is released, every register is cleared: control bits 0, period 0, duty 0, and `fl_pwm_o` is 0.
- R2: While `pwr_en` is low, the counter is held at zero and `fl_pwm_o` stays at the polarity level: 0, or 1 when inverted. Real-time clock edges change nothing during this time.
- R3: While the enable bit (control register at address 0, bit 0) is clear, the output and counter behave as in R2.
- R4: With period P (address 1, bits 7:0) and duty D (address 2, bits 8:0), the counter runs 0,1,..,P and then returns to 0, giving P+1 ticks per period. The un-inverted output is high exactly while count < D.
- R5: D greater than P gives a constant high un-inverted output. D = 0 gives a constant low one.
- R6: A write to period or duty while running takes effect only after the tick that ends the current period, or on a resync restart. While the output is held, written values are taken at once.
- R7: The invert bit (address 0, bit 1) flips `fl_pwm_o` in both the running and the held state, and it acts without waiting for a period boundary.
- R8: With the resync bit (address 0, bit 2) set, a rising edge on `tp_sync` restarts the counter at zero and loads pending values. With the bit clear, `tp_sync` is ignored.
- R9: The counter advances exactly once for each rising edge of `rtc_clk`, however long `rtc_clk` stays high. Falling edges do not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_fault_n | input | 1 | Active-low power fault; asynchronous clear of all state |
| pwr_en | input | 1 | Power-enable pin (asynchronous); low holds the output |
| rtc_clk | input | 1 | 32 kHz real-time clock (asynchronous level) |
| tp_sync | input | 1 | Touch-panel sync pulse (asynchronous level) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 period, 2 duty |
| reg_wdata | input | 9 | Register write data |
| fl_pwm_o | output | 1 | Front-light PWM output |

## Verification
On every cycle, the assertions check the following: the counter stays within the active period; it steps by one only on a count tick and holds otherwise; the held state produces the polarity level; an oversized duty gives a constant active level; active values change only at a boundary or a restart; and a restart lands on zero. Only the bench scenarios can show how register writes map to the waveform seen at the pin. These scenarios cover the exact duty pattern over several periods, deferred updates across a write made mid-period, the ignored sync pulse when resync is off, and the cleared state after a power fault that strikes while the block is running.

// File: rtl/flpwm_pkg.sv
package flpwm_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PER  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DUTY = 2'd2;

  // control register: bit 2 resync, bit 1 invert, bit 0 enable
  typedef struct packed {
    logic resync;
    logic invert;
    logic enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/flpwm_rst_sync.sv
module flpwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/flpwm_in_sync.sv
module flpwm_in_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;

    always_comb begin
      stg_d = {stg_q[STAGES-2:0], async_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= stg_d;
    end

    assign sync_o[b] = stg_q[STAGES-1];
  end

endmodule

// File: rtl/flpwm_regs.sv
module flpwm_regs
  import flpwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DUTY_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DUTY_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  per_o,
  output logic [DUTY_W-1:0] duty_o
);

  ctrl_t             ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  per_q,  per_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic              ctrl_en, per_en, duty_en;

  always_comb begin
    ctrl_en = we_i && (addr_i == ADDR_CTRL);
    per_en  = we_i && (addr_i == ADDR_PER);
    duty_en = we_i && (addr_i == ADDR_DUTY);
    ctrl_d  = ctrl_t'(wdata_i[CTRL_W-1:0]);
    per_d   = wdata_i[CNT_W-1:0];
    duty_d  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= '0;
      duty_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (per_en)  per_q  <= per_d;
      if (duty_en) duty_q <= duty_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign per_o  = per_q;
  assign duty_o = duty_q;

endmodule

// File: rtl/flpwm_core.sv
module flpwm_core
  import flpwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DUTY_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_en_s,
  input  logic              rtc_s,
  input  logic              sync_s,
  input  ctrl_t             ctrl_i,
  input  logic [CNT_W-1:0]  per_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);

  localparam int PAD_W = DUTY_W - CNT_W;

  logic              rtc_prev_q, sync_prev_q;
  logic              tick, restart, run, wrap;
  logic [CNT_W-1:0]  cnt_q,  cnt_d;
  logic [CNT_W-1:0]  per_q,  per_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic              out_q,  out_d;
  logic              below;

  always_comb begin
    run     = pwr_en_s && ctrl_i.enable;
    tick    = rtc_s && !rtc_prev_q;
    restart = ctrl_i.resync && sync_s && !sync_prev_q;
    wrap    = (cnt_q == per_q);

    cnt_d  = cnt_q;
    per_d  = per_q;
    duty_d = duty_q;
    if (!run) begin
      cnt_d  = '0;
      per_d  = per_i;
      duty_d = duty_i;
    end else if (restart) begin
      cnt_d  = '0;
      per_d  = per_i;
      duty_d = duty_i;
    end else if (tick) begin
      if (wrap) begin
        cnt_d  = '0;
        per_d  = per_i;
        duty_d = duty_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end

    below = ({{PAD_W{1'b0}}, cnt_q} < duty_q);
    out_d = ctrl_i.invert ^ (run && below);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rtc_prev_q  <= 1'b0;
      sync_prev_q <= 1'b0;
      cnt_q       <= '0;
      per_q       <= '0;
      duty_q      <= '0;
      out_q       <= 1'b0;
    end else begin
      rtc_prev_q  <= rtc_s;
      sync_prev_q <= sync_s;
      cnt_q       <= cnt_d;
      per_q       <= per_d;
      duty_q      <= duty_d;
      out_q       <= out_d;
    end
  end

  assign pwm_o = out_q;

endmodule

// File: rtl/flpwm_gen.sv
module flpwm_gen
  import flpwm_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DUTY_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              pwr_fault_n,
  input  logic              pwr_en,
  input  logic              rtc_clk,
  input  logic              tp_sync,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DUTY_W-1:0] reg_wdata,
  output logic              fl_pwm_o
);

  localparam int N_ASYNC = 3;

  logic               rst_n;
  logic [N_ASYNC-1:0] async_lv, sync_lv;
  ctrl_t              ctrl;
  logic [CNT_W-1:0]   per_reg;
  logic [DUTY_W-1:0]  duty_reg;

  flpwm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (pwr_fault_n),
    .rst_n_o (rst_n)
  );

  assign async_lv = {tp_sync, rtc_clk, pwr_en};

  flpwm_in_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (async_lv),
    .sync_o  (sync_lv)
  );

  flpwm_regs #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (reg_we),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .ctrl_o  (ctrl),
    .per_o   (per_reg),
    .duty_o  (duty_reg)
  );

  flpwm_core #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_en_s (sync_lv[0]),
    .rtc_s    (sync_lv[1]),
    .sync_s   (sync_lv[2]),
    .ctrl_i   (ctrl),
    .per_i    (per_reg),
    .duty_i   (duty_reg),
    .pwm_o    (fl_pwm_o)
  );

endmodule

// File: rtl/flpwm_gen_chk.sv
module flpwm_gen_chk #(
  parameter int CNT_W  = 8,
  parameter int DUTY_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              tick,
  input logic              restart,
  input logic              wrap,
  input logic              inv,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  per_q,
  input logic [DUTY_W-1:0] duty_q,
  input logic              pwm_o
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_low_R1: assert (pwm_o == 1'b0)
        else $error("output not cleared in reset");
    end
  end

  assert_forced_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pwm_o == $past(inv)));

  assert_cnt_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= per_q));

  assert_full_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (duty_q > {1'b0, per_q})) |=> (pwm_o == !$past(inv)));

  assert_hold_values_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && !(tick && wrap)) |=> ($stable(per_q) && $stable(duty_q)));

  assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && restart) |=> (cnt_q == '0));

  assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && tick && !wrap) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && !tick) |=> $stable(cnt_q));

endmodule

bind flpwm_core flpwm_gen_chk #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run),
  .tick    (tick),
  .restart (restart),
  .wrap    (wrap),
  .inv     (ctrl_i.invert),
  .cnt_q   (cnt_q),
  .per_q   (per_q),
  .duty_q  (duty_q),
  .pwm_o   (pwm_o)
);

// File: tb/flpwm_gen_tb.sv
module flpwm_gen_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       pwr_fault_n = 1'b0;
  logic       pwr_en = 1'b0;
  logic       rtc_clk = 1'b0;
  logic       tp_sync = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [8:0] reg_wdata = '0;
  logic       fl_pwm_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // reference model state
  int  m_cnt, m_per, m_duty, r_per, r_duty;
  bit  m_en, m_inv, m_rsy, m_pen;

  always #(CLK_PERIOD/2) clk = ~clk;

  flpwm_gen u_dut (
    .clk         (clk),
    .pwr_fault_n (pwr_fault_n),
    .pwr_en      (pwr_en),
    .rtc_clk     (rtc_clk),
    .tp_sync     (tp_sync),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .fl_pwm_o    (fl_pwm_o)
  );

  function automatic bit running();
    return m_en && m_pen;
  endfunction

  function automatic void m_refresh();
    if (!running()) begin
      m_cnt = 0; m_per = r_per; m_duty = r_duty;
    end
  endfunction

  function automatic bit m_out();
    return m_inv ^ (running() && (m_cnt < m_duty));
  endfunction

  task automatic check(input string req, input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: fl_pwm_o=%0b expected=%0b (cnt model %0d)", req, act, exp, m_cnt);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [8:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      2'd0: begin m_en = d[0]; m_inv = d[1]; m_rsy = d[2]; end
      2'd1: r_per = int'(d[7:0]);
      2'd2: r_duty = int'(d);
      default: ;
    endcase
    m_refresh();
    settle();
  endtask

  task automatic set_pen(input bit v);
    pwr_en = v; m_pen = v;
    m_refresh();
    settle();
  endtask

  task automatic tick(input int hi);
    @(negedge clk);
    rtc_clk = 1'b1;
    repeat (hi) @(negedge clk);
    rtc_clk = 1'b0;
    repeat (4) @(negedge clk);
    if (running()) begin
      if (m_cnt == m_per) begin
        m_cnt = 0; m_per = r_per; m_duty = r_duty;
      end else m_cnt++;
    end
  endtask

  task automatic ticks_check(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      tick(4);
      check(req, fl_pwm_o, m_out());
    end
  endtask

  task automatic sync_pulse();
    @(negedge clk);
    tp_sync = 1'b1;
    repeat (4) @(negedge clk);
    tp_sync = 1'b0;
    repeat (4) @(negedge clk);
    if (running() && m_rsy) begin
      m_cnt = 0; m_per = r_per; m_duty = r_duty;
    end
  endtask

  task automatic do_reset();
    pwr_fault_n = 1'b0;
    m_en = 0; m_inv = 0; m_rsy = 0; r_per = 0; r_duty = 0;
    m_refresh();
    repeat (3) @(negedge clk);
    check("R1 in reset", fl_pwm_o, 1'b0);
    pwr_fault_n = 1'b1;
    settle();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 after reset", fl_pwm_o, 1'b0);
    set_pen(1);
    ticks_check("R1 enable bit cleared by reset", 2);
  endtask

  task automatic t_basic();
    wr(2'd1, 9'd4);
    wr(2'd2, 9'd2);
    wr(2'd0, 9'b001);
    check("R4 start of period", fl_pwm_o, m_out());
    ticks_check("R4 duty pattern", 11);
    tick(25);
    check("R9 long high counts once", fl_pwm_o, m_out());
    tick(4);
    check("R9 next edge", fl_pwm_o, m_out());
  endtask

  task automatic t_const();
    wr(2'd2, 9'd300);
    ticks_check("R5 duty above period", 7);
    wr(2'd2, 9'd0);
    ticks_check("R5 zero duty", 7);
  endtask

  task automatic t_shadow();
    wr(2'd1, 9'd3);
    wr(2'd2, 9'd1);
    ticks_check("R4 new period", 5);
    tick(4);
    wr(2'd1, 9'd6);
    wr(2'd2, 9'd5);
    check("R6 write mid-period deferred", fl_pwm_o, m_out());
    ticks_check("R6 deferred values", 10);
  endtask

  task automatic t_invert();
    wr(2'd0, 9'b011);
    check("R7 invert immediate", fl_pwm_o, m_out());
    ticks_check("R7 inverted pattern", 8);
    set_pen(0);
    check("R7 invert while held", fl_pwm_o, 1'b1);
    set_pen(1);
    wr(2'd0, 9'b001);
  endtask

  task automatic t_force();
    wr(2'd1, 9'd4);
    wr(2'd2, 9'd3);
    ticks_check("R4 pre-hold", 2);
    set_pen(0);
    ticks_check("R2 pin low holds output", 4);
    set_pen(1);
    check("R2 resume from zero", fl_pwm_o, 1'b1);
    ticks_check("R2 resumed pattern", 6);
    wr(2'd0, 9'b000);
    ticks_check("R3 enable clear holds output", 4);
    wr(2'd2, 9'd1);
    wr(2'd0, 9'b001);
    ticks_check("R6 held state takes values at once", 6);
  endtask

  task automatic t_sync();
    wr(2'd1, 9'd7);
    wr(2'd2, 9'd4);
    wr(2'd0, 9'b101);
    ticks_check("R8 run", 6);
    sync_pulse();
    check("R8 resync restarts", fl_pwm_o, m_out());
    ticks_check("R8 after restart", 5);
    wr(2'd0, 9'b001);
    sync_pulse();
    check("R8 sync ignored when off", fl_pwm_o, m_out());
    ticks_check("R8 continues", 4);
  endtask

  task automatic t_fault();
    ticks_check("R1 pre-fault", 2);
    do_reset();
    set_pen(1);
    ticks_check("R1 cleared after fault", 3);
  endtask

  initial begin
    m_pen = 0; m_cnt = 0; m_per = 0; m_duty = 0;
    t_reset();
    t_basic();
    t_const();
    t_shadow();
    t_invert();
    t_force();
    t_sync();
    t_fault();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule